// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt sources for a small 8-bit processor core and drives two request lines into it: a high-priority request and a low-priority request. Software sees one 8-bit control/status word, `rd_data`. It holds two global enable bits, one enable bit for each of three built-in sources, and one flag bit for each of those sources. The three built-in sources are a timer-overflow pulse, an external-edge pulse, and a port-change detector. The port-change detector compares a set of watched pins against a snapshot that is taken when `port_snap` is pulsed. A bundle of peripheral request lines also enters the block. Each peripheral line is already flagged and enabled by its own peripheral and comes with a priority tag.

The `prio_mode` input selects how the two global bits are read. With `prio_mode` low, the block works in shared mode. Bit 7 is the master enable and bit 6 gates the peripheral bundle, and every request leaves on the high line. With `prio_mode` high, the block works in split mode. Bit 7 enables the high level and bit 6 enables the low level, and each source is routed by its tag. In both modes, clearing bit 7 silences everything.

A flag latches whenever its event occurs, whatever the enables hold, so software can poll for events. The request lines are produced by a three-state machine. Its states are QUIET, LOW and HIGH. From any state it goes to HIGH when a high request is due, to LOW when only a low request is due, and to QUIET otherwise. It is updated once per clock, so a request appears one cycle after the flag, enable or peripheral line that causes it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and both `irq_hi` and `irq_lo` are low.
- R2: A pulse on `tmr_ovf` or `ext_edge` sets flag bit 2 (timer) or flag bit 1 (external) on that clock edge, even when every enable bit is clear.
- R3: A write with `wr_en` loads `wr_data` into all eight bits of the word. Flag bits 2 and 1 therefore clear only when 0 is written to them. If a source event and a write of 0 to that source's flag fall in the same cycle, the flag ends up set.
- R4: Flag bit 0 sets in every cycle in which `port_pins` differs from the snapshot taken at the last `port_snap` pulse. While that mismatch persists, writing 0 to bit 0 does not clear it. After a snapshot that matches the pins, writing 0 does clear it.
- R5: In shared mode, `irq_hi` asserts when bit 7 is set and at least one built-in source has its flag (bits 2..0) and its enable (bits 5..3) both set. `irq_lo` never asserts in shared mode.
- R6: In shared mode, an active `periph_req` line raises `irq_hi` only when bit 7 and bit 6 are both set.
- R7: In split mode, `irq_hi` asserts when bit 7 is set and a pending source is tagged high. The tags are `src_hi[2]` for the timer, `src_hi[1]` for the external edge and `src_hi[0]` for port change, and `periph_hi[i]` for peripheral line i. With bit 7 clear, neither request line asserts in either mode.
- R8: In split mode, `irq_lo` asserts only when bit 7 and bit 6 are both set and a pending source is tagged low. Clearing bit 7 also suppresses it.
- R9: `irq_hi` and `irq_lo` are never high together. When high and low requests are both due, only `irq_hi` asserts. A request line follows its cause one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prio_mode | input | 1 | 0 = shared mode, 1 = split (two-level) mode |
| wr_en | input | 1 | Write strobe for the control/status word |
| wr_data | input | 8 | Value written to the control/status word |
| rd_data | output | 8 | Current control/status word |
| tmr_ovf | input | 1 | Timer overflow event pulse |
| ext_edge | input | 1 | External edge event pulse |
| port_pins | input | PORT_W | Watched pins for change detection |
| port_snap | input | 1 | Captures `port_pins` as the new snapshot |
| src_hi | input | 3 | Priority tags of the timer, external and port-change sources (1 = high) |
| periph_req | input | NPERIPH | Pending peripheral requests |
| periph_hi | input | NPERIPH | Priority tag per peripheral line (1 = high) |
| irq_hi | output | 1 | High-priority request to the core |
| irq_lo | output | 1 | Low-priority request to the core |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a source event and a software write of 0 to that source's flag. The bench provokes this by raising `tmr_ovf` in the very cycle that `wr_en` writes 0x00, and judges it correct only if flag bit 2 reads back as 1. The port-change mismatch against a flag clear is provoked the same way, and the flag must stay set until a matching snapshot is taken. The second pair is a high-tagged and a low-tagged request that are due together. Two peripheral lines with opposite tags are driven at once in split mode, and only `irq_hi` may be seen asserted.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int CW       = 8;
    localparam int NCORE    = 3;
    // core source index k: flag at bit k, enable at bit k+NCORE
    localparam int SRC_PC   = 0;
    localparam int SRC_EXT  = 1;
    localparam int SRC_TMR  = 2;
    localparam int B_GEN_L  = 6;
    localparam int B_GEN_H  = 7;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2
    } req_state_e;
endpackage

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pins,
    input  logic              snap,
    output logic              mismatch
);
    logic [PORT_W-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snap_q <= '0;
        else if (snap)
            snap_q <= pins;
    end

    assign mismatch = |(pins ^ snap_q);
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_prio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic [NCORE-1:0] evt,
    output logic [CW-1:0] ctrl
);
    // flags: event has precedence over a software write
    for (genvar k = 0; k < NCORE; k++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl[k] <= 1'b0;
            else if (evt[k])
                ctrl[k] <= 1'b1;
            else if (wr_en)
                ctrl[k] <= wr_data[k];
        end
    end

    // enables and global bits
    for (genvar b = NCORE; b < CW; b++) begin : g_en
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl[b] <= 1'b0;
            else if (wr_en)
                ctrl[b] <= wr_data[b];
        end
    end
endmodule

// File: rtl/irq_req_logic.sv
module irq_req_logic
    import irq_prio_pkg::*;
#(
    parameter int NPERIPH = 4
) (
    input  logic               prio_mode,
    input  logic [CW-1:0]      ctrl,
    input  logic [NCORE-1:0]   src_hi,
    input  logic [NPERIPH-1:0] periph_req,
    input  logic [NPERIPH-1:0] periph_hi,
    output logic               hi_cond,
    output logic               lo_cond
);
    logic [NCORE-1:0] core_pend;
    logic             gen_h, gen_l;
    logic             core_any, core_h, core_l, per_any, per_h, per_l;

    assign core_pend = ctrl[NCORE-1:0] & ctrl[2*NCORE-1:NCORE];
    assign gen_h     = ctrl[B_GEN_H];
    assign gen_l     = ctrl[B_GEN_L];

    assign core_any  = |core_pend;
    assign core_h    = |(core_pend & src_hi);
    assign core_l    = |(core_pend & ~src_hi);
    assign per_any   = |periph_req;
    assign per_h     = |(periph_req & periph_hi);
    assign per_l     = |(periph_req & ~periph_hi);

    always_comb begin
        if (prio_mode) begin
            hi_cond = gen_h & (core_h | per_h);
            lo_cond = gen_h & gen_l & (core_l | per_l);
        end else begin
            hi_cond = gen_h & (core_any | (gen_l & per_any));
            lo_cond = 1'b0;
        end
    end
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_prio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cond,
    input  logic lo_cond,
    output logic irq_hi,
    output logic irq_lo
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET, ST_LOW, ST_HIGH: begin
                if (hi_cond)
                    state_d = ST_HIGH;
                else if (lo_cond)
                    state_d = ST_LOW;
                else
                    state_d = ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        irq_hi = 1'b0;
        irq_lo = 1'b0;
        unique case (state_q)
            ST_HIGH:  irq_hi = 1'b1;
            ST_LOW:   irq_lo = 1'b1;
            ST_QUIET: ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NPERIPH = 4,
    parameter int PORT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prio_mode,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    input  logic               tmr_ovf,
    input  logic               ext_edge,
    input  logic [PORT_W-1:0]  port_pins,
    input  logic               port_snap,
    input  logic [2:0]         src_hi,
    input  logic [NPERIPH-1:0] periph_req,
    input  logic [NPERIPH-1:0] periph_hi,
    output logic               irq_hi,
    output logic               irq_lo
);
    logic             pc_mismatch;
    logic [NCORE-1:0] evt;
    logic [CW-1:0]    ctrl;
    logic             hi_cond, lo_cond;

    irq_port_watch #(.PORT_W(PORT_W)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (port_pins),
        .snap     (port_snap),
        .mismatch (pc_mismatch)
    );

    always_comb begin
        evt          = '0;
        evt[SRC_PC]  = pc_mismatch;
        evt[SRC_EXT] = ext_edge;
        evt[SRC_TMR] = tmr_ovf;
    end

    irq_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .evt     (evt),
        .ctrl    (ctrl)
    );

    assign rd_data = ctrl;

    irq_req_logic #(.NPERIPH(NPERIPH)) u_logic (
        .prio_mode  (prio_mode),
        .ctrl       (ctrl),
        .src_hi     (src_hi),
        .periph_req (periph_req),
        .periph_hi  (periph_hi),
        .hi_cond    (hi_cond),
        .lo_cond    (lo_cond)
    );

    irq_req_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_cond (hi_cond),
        .lo_cond (lo_cond),
        .irq_hi  (irq_hi),
        .irq_lo  (irq_lo)
    );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prio_mode,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       tmr_ovf,
    input logic       ext_edge,
    input logic       irq_hi,
    input logic       irq_lo
);
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_hi && irq_lo));

    p_tmr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> rd_data[2]);

    p_ext_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_edge |=> rd_data[1]);

    p_sw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[2] && !tmr_ovf) |=> !rd_data[2]);

    p_shared_no_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_mode |=> !irq_lo);

    p_master_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7] |=> (!irq_hi && !irq_lo));

    p_lo_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_mode && !rd_data[6]) |=> !irq_lo);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prio_mode (prio_mode),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .tmr_ovf   (tmr_ovf),
    .ext_edge  (ext_edge),
    .irq_hi    (irq_hi),
    .irq_lo    (irq_lo)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
    localparam int NP = 4;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prio_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          tmr_ovf = 1'b0;
    logic          ext_edge = 1'b0;
    logic [PW-1:0] port_pins = '0;
    logic          port_snap = 1'b0;
    logic [2:0]    src_hi = '0;
    logic [NP-1:0] periph_req = '0;
    logic [NP-1:0] periph_hi = '0;
    logic          irq_hi, irq_lo;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.NPERIPH(NP), .PORT_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tmr_ovf(tmr_ovf), .ext_edge(ext_edge),
        .port_pins(port_pins), .port_snap(port_snap),
        .src_hi(src_hi), .periph_req(periph_req), .periph_hi(periph_hi),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // advance one clock; inputs change and outputs are sampled at negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_tmr();
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
    endtask

    task automatic pulse_ext();
        ext_edge = 1'b1; step(); ext_edge = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 word", rd_data, 8'h00);
        chk("R1 irq_hi", irq_hi, 0);
        chk("R1 irq_lo", irq_lo, 0);
    endtask

    task automatic t_poll();
        prio_mode = 1'b0;
        pulse_ext();
        chk("R2 ext flag, enables off", rd_data, 8'h02);
        pulse_tmr();
        chk("R2 tmr flag, enables off", rd_data, 8'h06);
        wr(8'h86);   // master on, source enables off
        step();
        chk("R2 no request without enable", irq_hi, 0);
        wr(8'h00);
    endtask

    task automatic t_clear();
        wr(8'h38);
        chk("R3 enables written", rd_data, 8'h38);
        wr(8'h00);
        pulse_tmr();
        chk("R3 flag set", rd_data, 8'h04);
        tmr_ovf = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        step();
        tmr_ovf = 1'b0; wr_en = 1'b0;
        chk("R3 event beats clear", rd_data[2], 1);
        wr(8'h00);
        chk("R3 write 0 clears", rd_data, 8'h00);
    endtask

    task automatic t_port();
        port_pins = 4'b0100;
        step();
        chk("R4 mismatch sets flag", rd_data[0], 1);
        wr(8'h00);
        chk("R4 clear blocked by mismatch", rd_data[0], 1);
        port_snap = 1'b1; step(); port_snap = 1'b0;
        wr(8'h00);
        chk("R4 clear after snapshot", rd_data[0], 0);
        port_pins = 4'b0000;
        step();
        chk("R4 change back sets flag", rd_data[0], 1);
        port_snap = 1'b1; step(); port_snap = 1'b0;
        wr(8'h00);
    endtask

    task automatic t_shared_core();
        prio_mode = 1'b0;
        wr(8'hA0);
        pulse_tmr();
        chk("R9 one-cycle latency", irq_hi, 0);
        step();
        chk("R5 irq_hi on timer", irq_hi, 1);
        chk("R5 irq_lo stays low", irq_lo, 0);
        wr(8'h24);   // master off, flag held
        step();
        chk("R7 master off silences", irq_hi, 0);
        wr(8'h00);
    endtask

    task automatic t_shared_periph();
        prio_mode = 1'b0;
        periph_req = 4'b0001;
        wr(8'h80);
        step();
        chk("R6 no request without bit 6", irq_hi, 0);
        wr(8'hC0);
        step();
        chk("R6 request with bits 7 and 6", irq_hi, 1);
        chk("R5 shared mode no irq_lo", irq_lo, 0);
        periph_req = '0;
        wr(8'h00);
        step();
    endtask

    task automatic t_split_high();
        prio_mode = 1'b1; src_hi = 3'b100; periph_hi = 4'b0001;
        wr(8'hA0);
        pulse_tmr();
        step();
        chk("R7 high source raises irq_hi", irq_hi, 1);
        chk("R7 irq_lo low", irq_lo, 0);
        wr(8'h24);
        step();
        chk("R7 bit 7 clear silences", irq_hi, 0);
        wr(8'h00);
        step();
    endtask

    task automatic t_split_low();
        prio_mode = 1'b1; src_hi = 3'b100; periph_hi = 4'b0001;
        wr(8'h90);
        pulse_ext();
        step();
        chk("R8 no low request without bit 6", irq_lo, 0);
        wr(8'hD2);
        step();
        chk("R8 low source raises irq_lo", irq_lo, 1);
        chk("R8 low source not on irq_hi", irq_hi, 0);
        wr(8'h52);
        step();
        chk("R8 bit 7 clear suppresses irq_lo", irq_lo, 0);
        wr(8'hC0);
        periph_req = 4'b0010;
        step(); step();
        chk("R8 low peripheral raises irq_lo", irq_lo, 1);
        periph_req = 4'b0011;
        step();
        chk("R9 high preempts: irq_hi", irq_hi, 1);
        chk("R9 high preempts: irq_lo", irq_lo, 0);
        periph_req = '0;
        step();
        chk("R9 both idle", {irq_hi, irq_lo}, 2'b00);
        wr(8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_poll();
        t_clear();
        t_port();
        t_shared_core();
        t_shared_periph();
        t_split_high();
        t_split_low();
        summary();
        $finish;
    end
endmodule